// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a two-wire serial bus in front of a byte-wide memory, and it behaves like a serial EEPROM. SCL and SDA are brought into the system clock through a synchroniser. The block detects START and STOP conditions and shifts in bytes on rising SCL. It answers with an open-drain output enable: when `sda_oe_o` is 1 the line is pulled low, and when it is 0 the line is released. Up to four copies can share one bus, because each copy takes two strap inputs as part of its identity.

A write transfer carries a device-select byte, then a 16-bit word address (high byte first), then any number of data bytes. The data bytes collect in a 128-byte page buffer. After STOP, a self-timed interval copies the buffer into memory. During that interval the device-select byte is not acknowledged, so a master can poll until the device answers again. A read transfer returns bytes starting from the internal pointer. It can begin directly (current-address read), or it can follow a write that only loads the address and a repeated START (random read). The master continues a read with ACK and ends it with NACK and STOP. A write-protect input blocks all commits.

The word address is always 16 bits. The backing array holds 2^`MEM_AW` bytes, and higher address bits alias onto it. The default `MEM_AW` is 11 so the default build stays small; set it to 16 for the full 64K x 8 array. The interval length is `WR_CYCLES` system clocks and must be at least 128.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The device-select byte is acknowledged only when bits [7:3] equal 10100, bits [2:1] equal `strap_i[1:0]` and no write interval is running. Bit 0 = 1 selects a read and 0 selects a write. A byte that does not match gets no ACK (SDA released in the ninth clock), and the block ignores the bus until the next START.
- R2: After a write select, the next two bytes are acknowledged and load the 16-bit word pointer, high byte first.
- R3: When write-protect is low, each data byte is acknowledged and buffered. After STOP, every buffered byte, from 1 up to a full page, is committed to memory at the address it was given. Bytes of the page that were not written keep their old contents.
- R4: Within a write transfer, the low 7 pointer bits advance after each data byte and wrap from 127 to 0. The upper 9 bits stay fixed. More than 128 bytes overwrite the earlier page offsets, and the last value written to an offset wins.
- R5: When `wp_i` is high, the device-select and address bytes are still acknowledged. Data bytes get no ACK, memory is unchanged, and no write interval starts.
- R6: A STOP that ends a write with committed data starts an interval of `WR_CYCLES` clocks. During the interval the device-select byte gets no ACK. After it ends, the device-select byte is acknowledged again.
- R7: A read select with no preceding address returns the byte at the current pointer. The pointer then advances by one.
- R8: A write select with two address bytes, then a repeated START and a read select, returns the byte at the given address.
- R9: During a read, master ACK continues with the next byte, and the 16-bit pointer rolls over from 0xFFFF to 0x0000. Master NACK ends the read.
- R10: `sda_oe_o` changes only while SCL is low: data is captured on rising SCL and driven after falling SCL.
- R11: After reset, `sda_oe_o` is 0, no write interval is running, and a matching device-select byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired level) |
| strap_i | input | 2 | Device identity straps, tie to 0 when unused |
| wp_i | input | 1 | Write protect, 1 blocks every commit |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench aims at these corner cases:
- A page write that starts two bytes before the end of a page. If the carry leaked into the upper bits, the next page would be corrupted; the bench also reads a byte it placed there in advance.
- A 130-byte write, whose first two offsets must hold the last two bytes sent. If the second pass were dropped or offset, the readback differs.
- Acknowledge polling: the first poll after STOP must be refused and a later poll accepted. A design that ignored the busy interval would ACK the first poll; one that never cleared it would hang the poll loop.
- A write under protection that acknowledges the address but refuses the data and starts no interval.
- A sequential read across 0xFFFF. If the rollover were missing, or confined to a page, the byte after 0xFFFF would not be the one stored at 0x0000.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int WORD_AW    = 16;
    localparam int PAGE_AW    = 7;
    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int BASE_W     = WORD_AW - PAGE_AW;
    localparam logic [4:0] SELECT_PREFIX = 5'b10100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK,
        PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {
        BY_SELECT,
        BY_ADDR_HI,
        BY_ADDR_LO,
        BY_DATA
    } byte_role_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic               we;
        logic [PAGE_AW-1:0] off;
        logic [7:0]         data;
    } buf_wr_t;

    function automatic logic select_hit(logic [7:0] b, logic [1:0] strap);
        return (b[7:3] == SELECT_PREFIX) && (b[2:1] == strap);
    endfunction

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync
    import eeprom_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/eeprom_proto.sv
module eeprom_proto
    import eeprom_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev_i,
    input  logic [1:0]         strap_i,
    input  logic               wp_i,
    input  logic               busy_i,
    input  logic [7:0]         rd_data_i,
    output logic               sda_oe_o,
    output logic [WORD_AW-1:0] ptr_o,
    output buf_wr_t            buf_wr_o,
    output logic               buf_clr_o,
    output logic               commit_o
);

    phase_e             phase;
    byte_role_e         role;
    logic [3:0]         cnt;
    logic [7:0]         rx_sh;
    logic [7:0]         tx_sh;
    logic [7:0]         addr_hi;
    logic [WORD_AW-1:0] ptr;
    logic               go_tx;
    logic               mack;
    logic               wr_seen;
    logic               oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            role      <= BY_SELECT;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            addr_hi   <= '0;
            ptr       <= '0;
            go_tx     <= 1'b0;
            mack      <= 1'b1;
            wr_seen   <= 1'b0;
            oe        <= 1'b0;
            buf_wr_o  <= '0;
            buf_clr_o <= 1'b0;
            commit_o  <= 1'b0;
        end else begin
            buf_wr_o.we <= 1'b0;
            buf_clr_o   <= 1'b0;
            commit_o    <= 1'b0;
            if (ev_i.start) begin
                phase <= PH_RX;
                role  <= BY_SELECT;
                cnt   <= '0;
                oe    <= 1'b0;
            end else if (ev_i.stop) begin
                phase    <= PH_IDLE;
                oe       <= 1'b0;
                commit_o <= wr_seen;
                wr_seen  <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (ev_i.scl_rise) begin
                            rx_sh <= {rx_sh[6:0], ev_i.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev_i.scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            unique case (role)
                                BY_SELECT: begin
                                    if (select_hit(rx_sh, strap_i) && !busy_i) begin
                                        oe    <= 1'b1;
                                        phase <= PH_RX_ACK;
                                        go_tx <= rx_sh[0];
                                        role  <= BY_ADDR_HI;
                                    end else begin
                                        phase <= PH_WAIT;
                                    end
                                end
                                BY_ADDR_HI: begin
                                    addr_hi <= rx_sh;
                                    oe      <= 1'b1;
                                    phase   <= PH_RX_ACK;
                                    go_tx   <= 1'b0;
                                    role    <= BY_ADDR_LO;
                                end
                                BY_ADDR_LO: begin
                                    ptr       <= {addr_hi, rx_sh};
                                    buf_clr_o <= 1'b1;
                                    oe        <= 1'b1;
                                    phase     <= PH_RX_ACK;
                                    go_tx     <= 1'b0;
                                    role      <= BY_DATA;
                                end
                                BY_DATA: begin
                                    if (!wp_i) begin
                                        buf_wr_o.we   <= 1'b1;
                                        buf_wr_o.off  <= ptr[PAGE_AW-1:0];
                                        buf_wr_o.data <= rx_sh;
                                        ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
                                        wr_seen <= 1'b1;
                                        oe      <= 1'b1;
                                        phase   <= PH_RX_ACK;
                                        go_tx   <= 1'b0;
                                    end else begin
                                        phase <= PH_WAIT;
                                    end
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev_i.scl_fall) begin
                            if (go_tx) begin
                                tx_sh <= rd_data_i;
                                oe    <= ~rd_data_i[7];
                                cnt   <= 4'd1;
                                phase <= PH_TX;
                            end else begin
                                oe    <= 1'b0;
                                phase <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev_i.scl_fall) begin
                            if (cnt == 4'd8) begin
                                oe    <= 1'b0;
                                ptr   <= ptr + 1'b1;
                                phase <= PH_TX_ACK;
                            end else begin
                                oe    <= ~tx_sh[6];
                                tx_sh <= {tx_sh[6:0], 1'b0};
                                cnt   <= cnt + 4'd1;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev_i.scl_rise) begin
                            mack <= ev_i.sda;
                        end else if (ev_i.scl_fall) begin
                            if (!mack) begin
                                tx_sh <= rd_data_i;
                                oe    <= ~rd_data_i[7];
                                cnt   <= 4'd1;
                                phase <= PH_TX;
                            end else begin
                                phase <= PH_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = oe;
    assign ptr_o    = ptr;

    // R10
    oe_rises_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> !ev_i.scl);

    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !oe);

    // R5
    protected_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        wp_i |=> !buf_wr_o.we);

    // R4
    page_upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        buf_wr_o.we |-> ptr[WORD_AW-1:PAGE_AW] == $past(ptr[WORD_AW-1:PAGE_AW]));

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
    import eeprom_pkg::*;
#(
    parameter int MEM_AW    = 11,
    parameter int WR_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WORD_AW-1:0] ptr_i,
    input  buf_wr_t            buf_wr_i,
    input  logic               buf_clr_i,
    input  logic               commit_i,
    input  logic               wp_i,
    output logic               busy_o,
    output logic [7:0]         rd_data_o
);

    localparam int TW    = $clog2(WR_CYCLES + 1);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic [BASE_W-1:0]     page_base;
    logic [7:0]            mem [DEPTH];
    logic                  busy;
    logic [TW-1:0]         tmr;
    logic [PAGE_AW-1:0]    c_off;
    logic [WORD_AW-1:0]    c_addr;
    logic                  c_we;

    always_ff @(posedge clk) begin
        if (buf_wr_i.we) begin
            pbuf[buf_wr_i.off] <= buf_wr_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pvalid    <= '0;
            page_base <= '0;
            busy      <= 1'b0;
            tmr       <= '0;
        end else begin
            if (buf_clr_i) begin
                pvalid    <= '0;
                page_base <= ptr_i[WORD_AW-1:PAGE_AW];
            end else if (buf_wr_i.we) begin
                pvalid[buf_wr_i.off] <= 1'b1;
            end
            if (commit_i && !busy) begin
                if (!wp_i && (|pvalid)) begin
                    busy <= 1'b1;
                    tmr  <= '0;
                end else begin
                    pvalid <= '0;
                end
            end else if (busy) begin
                if (tmr == TW'(WR_CYCLES - 1)) begin
                    busy   <= 1'b0;
                    pvalid <= '0;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

    assign c_off  = tmr[PAGE_AW-1:0];
    assign c_addr = {page_base, c_off};
    assign c_we   = busy && (tmr < TW'(PAGE_BYTES)) && pvalid[c_off];

    always_ff @(posedge clk) begin
        if (c_we) begin
            mem[c_addr[MEM_AW-1:0]] <= pbuf[c_off];
        end
    end

    assign rd_data_o = mem[ptr_i[MEM_AW-1:0]];
    assign busy_o    = busy;

    // R6
    busy_from_commit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_i));

    // R5
    busy_needs_unprotected_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp_i));

    // R6
    no_fill_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        buf_wr_i.we |-> !busy);

    // R4
    fill_same_page_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_wr_i.we && !$past(buf_clr_i)) |-> page_base == ptr_i[WORD_AW-1:PAGE_AW]);

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int MEM_AW      = 11,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe_o
);

    bus_ev_t            ev;
    logic [WORD_AW-1:0] ptr;
    buf_wr_t            buf_wr;
    logic               buf_clr;
    logic               commit;
    logic               busy;
    logic [7:0]         rd_data;

    eeprom_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eeprom_proto u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev),
        .strap_i   (strap_i),
        .wp_i      (wp_i),
        .busy_i    (busy),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe_o),
        .ptr_o     (ptr),
        .buf_wr_o  (buf_wr),
        .buf_clr_o (buf_clr),
        .commit_o  (commit)
    );

    eeprom_store #(.MEM_AW(MEM_AW), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ptr_i     (ptr),
        .buf_wr_i  (buf_wr),
        .buf_clr_i (buf_clr),
        .commit_i  (commit),
        .wp_i      (wp_i),
        .busy_o    (busy),
        .rd_data_o (rd_data)
    );

    // R11
    reset_released_chk: assert property (@(posedge clk)
        $past(rst) |-> !sda_oe_o);

endmodule

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;

    localparam int MEM_AW = 11;
    localparam int Q      = 5;
    localparam int MASK   = (1 << MEM_AW) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic       wp = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       sda_oe;
    logic       sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    int hi_changes = 0;
    logic scl_p = 1'b1;
    logic oe_p  = 1'b0;
    byte unsigned model [int];

    assign sda_line = msda & ~sda_oe;

    always #5 clk = ~clk;

    serial_eeprom_slave #(.MEM_AW(MEM_AW)) uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // R10 monitor: the output enable must hold while SCL stays high
    always @(posedge clk) begin
        if (!rst && scl_p && scl && (sda_oe != oe_p)) hi_changes++;
        scl_p <= scl;
        oe_p  <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        scl = 1'b0; tick(Q); msda = b; tick(Q); scl = 1'b1; tick(2 * Q);
    endtask

    task automatic recv_bit(output logic b);
        scl = 1'b0; tick(Q); msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
    endtask

    task automatic start_cond();
        scl = 1'b0; tick(Q); msda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        msda = 1'b0; tick(Q);
    endtask

    task automatic stop_cond();
        scl = 1'b0; tick(Q); msda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        msda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    function automatic logic [7:0] sel(input logic [1:0] s, input logic rd);
        return {5'b10100, s, rd};
    endfunction

    // poll with a write select; returns number of polls until ACK
    task automatic wait_ready(output int polls);
        logic a;
        polls = 0;
        for (int k = 0; k < 40; k++) begin
            start_cond();
            send_byte(sel(strap, 1'b0), a);
            stop_cond();
            polls++;
            if (a) break;
        end
    endtask

    task automatic write_block(input string req, input logic [15:0] addr,
                               input byte unsigned data [$], input logic exp_data_ack);
        logic a;
        int   polls;
        start_cond();
        send_byte(sel(strap, 1'b0), a);
        check(req, "write select ack", int'(a), 1);
        send_byte(addr[15:8], a);
        check("R2", "address high ack", int'(a), 1);
        send_byte(addr[7:0], a);
        check("R2", "address low ack", int'(a), 1);
        foreach (data[i]) begin
            logic [6:0] off;
            send_byte(data[i], a);
            off = addr[6:0] + 7'(i);
            if (i == 0) check(req, "data ack", int'(a), int'(exp_data_ack));
            if (exp_data_ack) model[int'({addr[15:7], off}) & MASK] = data[i];
            if (!a) break;
        end
        stop_cond();
        if (exp_data_ack) begin
            wait_ready(polls);
            check("R6", "polls until ready in range", int'(polls >= 2 && polls <= 12), 1);
        end
    endtask

    task automatic check_bytes(input string req, input logic [15:0] a0, input int n,
                               input logic [7:0] got [$]);
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = int'(16'(a0 + 16'(i))) & MASK;
            if (model.exists(idx)) check(req, $sformatf("byte at %0h", 16'(a0 + 16'(i))),
                                         int'(got[i]), int'(model[idx]));
        end
    endtask

    task automatic read_at(input string req, input logic [15:0] addr, input int n);
        logic a;
        logic [7:0] d;
        logic [7:0] got [$];
        start_cond();
        send_byte(sel(strap, 1'b0), a);
        check(req, "dummy write select ack", int'(a), 1);
        send_byte(addr[15:8], a);
        send_byte(addr[7:0], a);
        start_cond();
        send_byte(sel(strap, 1'b1), a);
        check(req, "read select ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            got.push_back(d);
        end
        stop_cond();
        check_bytes(req, addr, n, got);
    endtask

    initial begin
        tick(190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        int polls;
        byte unsigned q [$];

        tick(5);
        rst = 1'b0;
        tick(3);
        // R11 reset state
        check("R11", "sda_oe after reset", int'(sda_oe), 0);
        wait_ready(polls);
        check("R11", "select acked at once after reset", polls, 1);

        // R1 identity decode
        start_cond(); send_byte(sel(2'b01, 1'b0), a); stop_cond();
        check("R1", "strap mismatch nack", int'(a), 0);
        start_cond(); send_byte(8'hB4, a); stop_cond();
        check("R1", "prefix mismatch nack", int'(a), 0);
        strap = 2'b01;
        start_cond(); send_byte(sel(2'b01, 1'b0), a); stop_cond();
        check("R1", "new strap matches", int'(a), 1);
        strap = 2'b10;

        // R3 R6 two-byte write, then R8 random read and R7 current read
        q = '{8'hA5, 8'h3C};
        start_cond(); send_byte(sel(strap, 1'b0), a);
        send_byte(8'h16, a); send_byte(8'h34, a);
        send_byte(8'hA5, a); check("R3", "first data ack", int'(a), 1);
        send_byte(8'h3C, a); check("R3", "second data ack", int'(a), 1);
        stop_cond();
        model[16'h1634 & MASK] = 8'hA5;
        model[16'h1635 & MASK] = 8'h3C;
        start_cond(); send_byte(sel(strap, 1'b0), a); stop_cond();
        check("R6", "first poll refused while busy", int'(a), 0);
        wait_ready(polls);
        check("R6", "ready after interval", int'(polls >= 1 && polls <= 12), 1);
        read_at("R8", 16'h1634, 1);
        start_cond(); send_byte(sel(strap, 1'b1), a);
        check("R7", "current read select ack", int'(a), 1);
        recv_byte(1'b0, d); stop_cond();
        check("R7", "current address byte", int'(d), int'(8'h3C));

        // R3 partial page, R9 sequential read
        q = '{8'h11, 8'h22, 8'h33, 8'h44};
        write_block("R3", 16'h0105, q, 1'b1);
        read_at("R9", 16'h0105, 4);

        // R4 wrap within page
        q = '{8'h99};
        write_block("R4", 16'h0280, q, 1'b1);
        q = '{8'hC1, 8'hC2, 8'hC3, 8'hC4};
        write_block("R4", 16'h027E, q, 1'b1);
        read_at("R4", 16'h027E, 2);
        read_at("R4", 16'h0200, 2);
        read_at("R4", 16'h0280, 1);

        // R4 more than one page of data
        q.delete();
        for (int i = 0; i < 130; i++) q.push_back(byte'(i ^ 8'h5A));
        write_block("R4", 16'h0400, q, 1'b1);
        read_at("R4", 16'h0400, 3);
        read_at("R4", 16'h047F, 1);

        // R5 write protect
        wp = 1'b1;
        q = '{8'h00};
        write_block("R5", 16'h1634, q, 1'b0);
        wait_ready(polls);
        check("R5", "no interval under protect", polls, 1);
        wp = 1'b0;
        read_at("R5", 16'h1634, 1);

        // R9 rollover of the full pointer
        q = '{8'h77};
        write_block("R9", 16'hFFFF, q, 1'b1);
        q = '{8'h88};
        write_block("R9", 16'h0000, q, 1'b1);
        read_at("R9", 16'hFFFF, 2);

        // R10 output enable held while SCL high
        check("R10", "sda_oe changes with SCL high", hi_changes, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule